// File: doc/BRIEF.md
# Monitoring Command Sequencer

This block sits between a software register interface and an external optical-monitoring device. Software writes a 2-bit command that asks for either one read or continuous polling at one of three speeds. It reads back a 2-bit status that tracks the command's progress. The block talks to the device through an abstract request/acknowledge/error handshake. On each successful fetch it captures the monitor bytes and six warning flags, and it holds them steady for software to read.

The status is guarded. A new command is taken only while the status shows idle. A finished result (success or failure) stays visible until software reads it. Polling speeds come from a per-speed base count, scaled by a separate rate field. When a hardware or soft reset ends, the block can start fastest-speed polling by itself if an external enable pin and a monitoring-control bit are both set. In indirect mode the device is asked for one representative lane. Otherwise lane 0 is used.

Top module: `mon_cmd_seq`

## Requirements
- R1: After reset the status is 00 (idle), `dev_req_o` is low, and the captured bytes and flags are all zero.
- R2: A command write of type 00 (single read) while idle makes the status 10 and raises `dev_req_o` in the next cycle. An acknowledge ends the read with status 01 and captures `dev_data_i`.
- R3: While the status is not 00, a command write has no effect on status, requests or captured values. The only exception is the stop write of R9.
- R4: A status of 01 (success) or 11 (failed) holds until a cycle with `stat_rd_i` high. In the cycle after that read the status is 00.
- R5: An error response during a request ends the command with status 11 and leaves the captured bytes and flags unchanged.
- R6: If a request sees neither acknowledge nor error for `WD_CYC` cycles (default 16), `dev_req_o` drops and the status becomes 11.
- R7: Command types 01, 10 and 11 start periodic polling. The status stays 10 while polling runs, and each acknowledge updates the captured bytes and flags.
- R8: During polling, `dev_req_o` stays low for exactly base << `rate_cfg_i` cycles between an acknowledge and the next request. The base is 40 for type 01 (slowest), 24 for type 10 and 12 for type 11 (fastest).
- R9: A write of type 00 while polling waits between fetches ends polling. The status becomes 00 and no further request is made.
- R10: `dev_lane_o` carries `rep_lane_i` as sampled at command launch when `indirect_i` is high at launch, and 0 otherwise.
- R11: When hardware reset ends with both `auto_pin_i` and `mon_ctrl_i` high, fastest-speed polling (type 11) starts with no software write. If either input is low, no request is made.
- R12: A `soft_rst_i` pulse ends any command, returns the status to 00 and clears the captured values. When it ends, it starts polling under the same condition as R11.
- R13: Captured bytes and flags change only at an accepted acknowledge, never in part. Flag bits are: 0 bias current high, 1 bias current low, 2 transmit power high, 3 transmit power low, 4 receive power high, 5 receive power low. A 1 means the warning is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| soft_rst_i | input | 1 | Synchronous soft reset |
| auto_pin_i | input | 1 | External enable for auto start |
| mon_ctrl_i | input | 1 | Monitoring-control bit for auto start |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_type_i | input | 2 | Command type written |
| stat_rd_i | input | 1 | Status read strobe |
| stat_o | output | 2 | Command status |
| rate_cfg_i | input | 2 | Polling interval scale (left shift) |
| indirect_i | input | 1 | Indirect multi-lane mode |
| rep_lane_i | input | 2 | Representative lane select |
| dev_req_o | output | 1 | Fetch request to the device |
| dev_lane_o | output | 2 | Lane asked for |
| dev_ack_i | input | 1 | Fetch done, data valid |
| dev_err_i | input | 1 | Fetch failed |
| dev_data_i | input | NBYTES*8 | Monitor bytes from the device |
| dev_flags_i | input | 6 | Warning flags from the device |
| mon_data_o | output | NBYTES*8 | Captured monitor bytes |
| warn_o | output | 6 | Captured warning flags |

## Verification
The bench targets command writes made during a fetch and during a held result. A missing guard would start a second command or turn a single read into polling. It counts the exact low gap between polling requests at several type and rate pairs, which exposes an off-by-one or a swapped base count. It drives garbage data without an acknowledge, and drives an error with fresh data, to catch capture that is not atomic. It exercises both reset paths with the enable inputs set and cleared. A design that ignored either input, or skipped the soft-reset path, would start polling wrongly or never.

// File: rtl/mon_seq_pkg.sv
package mon_seq_pkg;
  typedef enum logic [1:0] {
    STAT_IDLE = 2'b00,
    STAT_OK   = 2'b01,
    STAT_BUSY = 2'b10,
    STAT_FAIL = 2'b11
  } stat_e;

  typedef enum logic [1:0] {
    CT_SINGLE = 2'b00,
    CT_SLOW   = 2'b01,
    CT_MID    = 2'b10,
    CT_FAST   = 2'b11
  } ctype_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_WAIT,
    SQ_HOLD
  } sq_state_e;

  localparam int FLAG_W = 6;
endpackage

// File: rtl/mon_seq_interval.sv
module mon_seq_interval
  import mon_seq_pkg::*;
#(
  parameter int SLOW_CYC = 40,
  parameter int MID_CYC  = 24,
  parameter int FAST_CYC = 12,
  parameter int CW       = 9
) (
  input  ctype_e          ctype_i,
  input  logic [1:0]      rate_i,
  output logic [CW-1:0]   interval_o
);
  logic [CW-1:0] base;

  always_comb begin
    unique case (ctype_i)
      CT_SLOW: base = CW'(SLOW_CYC);
      CT_MID:  base = CW'(MID_CYC);
      default: base = CW'(FAST_CYC);
    endcase
    interval_o = base << rate_i;
  end
endmodule

// File: rtl/mon_seq_capture.sv
module mon_seq_capture
  import mon_seq_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  cap_en_i,
  input  logic [NBYTES*8-1:0]   data_i,
  input  logic [FLAG_W-1:0]     flags_i,
  output logic [NBYTES*8-1:0]   data_o,
  output logic [FLAG_W-1:0]     flags_o
);
  logic [FLAG_W-1:0] flags_q, flags_d;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] byte_q, byte_d;
    always_comb begin
      byte_d = byte_q;
      if (clr_i)         byte_d = '0;
      else if (cap_en_i) byte_d = data_i[b*8 +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end
    assign data_o[b*8 +: 8] = byte_q;
  end

  always_comb begin
    flags_d = flags_q;
    if (clr_i)         flags_d = '0;
    else if (cap_en_i) flags_d = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/mon_seq_fsm.sv
module mon_seq_fsm
  import mon_seq_pkg::*;
#(
  parameter int CW     = 9,
  parameter int WD_CYC = 16,
  localparam int WDW   = $clog2(WD_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst_i,
  input  logic           auto_go_i,
  input  logic           cmd_wr_i,
  input  logic [1:0]     cmd_type_i,
  input  logic           stat_rd_i,
  input  logic           dev_ack_i,
  input  logic           dev_err_i,
  input  logic [CW-1:0]  interval_i,
  output ctype_e         ctype_o,
  output logic           dev_req_o,
  output logic           cap_en_o,
  output logic           launch_o,
  output stat_e          stat_o
);
  sq_state_e       st_q, st_d;
  ctype_e          type_q, type_d;
  stat_e           code_q, code_d;
  logic [WDW-1:0]  wd_q, wd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            boot_q, boot_d;

  always_comb begin
    st_d     = st_q;
    type_d   = type_q;
    code_d   = code_q;
    wd_d     = wd_q;
    cnt_d    = cnt_q;
    boot_d   = 1'b0;
    cap_en_o = 1'b0;
    launch_o = 1'b0;
    if (soft_rst_i) begin
      st_d   = SQ_IDLE;
      boot_d = 1'b1;
      wd_d   = '0;
      cnt_d  = '0;
    end else if (boot_q && auto_go_i) begin
      st_d     = SQ_REQ;
      type_d   = CT_FAST;
      wd_d     = '0;
      launch_o = 1'b1;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (cmd_wr_i) begin
            st_d     = SQ_REQ;
            type_d   = ctype_e'(cmd_type_i);
            wd_d     = '0;
            launch_o = 1'b1;
          end
        end
        SQ_REQ: begin
          if (dev_err_i) begin
            st_d   = SQ_HOLD;
            code_d = STAT_FAIL;
          end else if (dev_ack_i) begin
            cap_en_o = 1'b1;
            if (type_q == CT_SINGLE) begin
              st_d   = SQ_HOLD;
              code_d = STAT_OK;
            end else begin
              st_d  = SQ_WAIT;
              cnt_d = interval_i - CW'(1);
            end
          end else if (wd_q == WDW'(WD_CYC - 1)) begin
            st_d   = SQ_HOLD;
            code_d = STAT_FAIL;
          end else begin
            wd_d = wd_q + WDW'(1);
          end
        end
        SQ_WAIT: begin
          if (cmd_wr_i && cmd_type_i == CT_SINGLE) begin
            st_d = SQ_IDLE;
          end else if (cnt_q == '0) begin
            st_d = SQ_REQ;
            wd_d = '0;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: begin
          if (stat_rd_i) st_d = SQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      type_q <= CT_SINGLE;
      code_q <= STAT_IDLE;
      wd_q   <= '0;
      cnt_q  <= '0;
      boot_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      type_q <= type_d;
      code_q <= code_d;
      wd_q   <= wd_d;
      cnt_q  <= cnt_d;
      boot_q <= boot_d;
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_IDLE: stat_o = STAT_IDLE;
      SQ_HOLD: stat_o = code_q;
      default: stat_o = STAT_BUSY;
    endcase
  end

  assign dev_req_o = (st_q == SQ_REQ);
  assign ctype_o   = type_q;
endmodule

// File: rtl/mon_cmd_seq.sv
module mon_cmd_seq
  import mon_seq_pkg::*;
#(
  parameter int NBYTES   = 4,
  parameter int SLOW_CYC = 40,
  parameter int MID_CYC  = 24,
  parameter int FAST_CYC = 12,
  parameter int WD_CYC   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst_i,
  input  logic                 auto_pin_i,
  input  logic                 mon_ctrl_i,
  input  logic                 cmd_wr_i,
  input  logic [1:0]           cmd_type_i,
  input  logic                 stat_rd_i,
  output logic [1:0]           stat_o,
  input  logic [1:0]           rate_cfg_i,
  input  logic                 indirect_i,
  input  logic [1:0]           rep_lane_i,
  output logic                 dev_req_o,
  output logic [1:0]           dev_lane_o,
  input  logic                 dev_ack_i,
  input  logic                 dev_err_i,
  input  logic [NBYTES*8-1:0]  dev_data_i,
  input  logic [5:0]           dev_flags_i,
  output logic [NBYTES*8-1:0]  mon_data_o,
  output logic [5:0]           warn_o
);
  localparam int CW = $clog2((SLOW_CYC << 3) + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_s;
  ctype_e        ctype;
  logic [CW-1:0] interval;
  logic          cap_en, launch;
  stat_e         stat;
  logic [1:0]    lane_q, lane_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  mon_seq_interval #(
    .SLOW_CYC(SLOW_CYC), .MID_CYC(MID_CYC), .FAST_CYC(FAST_CYC), .CW(CW)
  ) u_interval (
    .ctype_i(ctype), .rate_i(rate_cfg_i), .interval_o(interval)
  );

  mon_seq_fsm #(.CW(CW), .WD_CYC(WD_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_s), .soft_rst_i(soft_rst_i),
    .auto_go_i(auto_pin_i & mon_ctrl_i),
    .cmd_wr_i(cmd_wr_i), .cmd_type_i(cmd_type_i), .stat_rd_i(stat_rd_i),
    .dev_ack_i(dev_ack_i), .dev_err_i(dev_err_i), .interval_i(interval),
    .ctype_o(ctype), .dev_req_o(dev_req_o), .cap_en_o(cap_en),
    .launch_o(launch), .stat_o(stat)
  );

  mon_seq_capture #(.NBYTES(NBYTES)) u_capture (
    .clk(clk), .rst_n(rst_s), .clr_i(soft_rst_i), .cap_en_i(cap_en),
    .data_i(dev_data_i), .flags_i(dev_flags_i),
    .data_o(mon_data_o), .flags_o(warn_o)
  );

  always_comb begin
    lane_d = lane_q;
    if (launch) lane_d = indirect_i ? rep_lane_i : 2'd0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) lane_q <= 2'd0;
    else        lane_q <= lane_d;
  end

  assign dev_lane_o = lane_q;
  assign stat_o     = stat;
endmodule

// File: rtl/mon_cmd_seq_chk.sv
module mon_cmd_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst_i,
  input logic          cmd_wr_i,
  input logic          stat_rd_i,
  input logic [1:0]    stat_o,
  input logic          dev_req_o,
  input logic          dev_ack_i,
  input logic          dev_err_i,
  input logic [DW-1:0] mon_data_o,
  input logic [5:0]    warn_o
);
  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o == 2'b00 && cmd_wr_i && !soft_rst_i) |=> (stat_o == 2'b10 && dev_req_o));

  p_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[0] && cmd_wr_i && !stat_rd_i && !soft_rst_i) |=> $stable(stat_o));

  p_hold_until_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[0] && !stat_rd_i && !soft_rst_i) |=> $stable(stat_o));

  p_fail_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_o && dev_err_i && !soft_rst_i) |=> (stat_o == 2'b11 && !dev_req_o));

  p_capture_atomic_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dev_req_o && dev_ack_i) && !soft_rst_i) |=> ($stable(mon_data_o) && $stable(warn_o)));
endmodule

bind mon_cmd_seq mon_cmd_seq_chk #(.DW(NBYTES*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .cmd_wr_i(cmd_wr_i),
  .stat_rd_i(stat_rd_i), .stat_o(stat_o), .dev_req_o(dev_req_o),
  .dev_ack_i(dev_ack_i), .dev_err_i(dev_err_i),
  .mon_data_o(mon_data_o), .warn_o(warn_o)
);

// File: tb/sim_mon_cmd_seq.sv
module sim_mon_cmd_seq;
  localparam int SLOW = 40, MID = 24, FAST = 12, WD = 16;

  logic clk = 1'b0;
  logic rst_n, soft_rst, auto_pin, mon_ctrl, cmd_wr, stat_rd;
  logic [1:0] cmd_type, stat, rate_cfg, rep_lane, dev_lane;
  logic indirect, dev_req, dev_ack, dev_err;
  logic [31:0] dev_data, mon_data;
  logic [5:0] dev_flags, warn;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mon_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .auto_pin_i(auto_pin),
    .mon_ctrl_i(mon_ctrl), .cmd_wr_i(cmd_wr), .cmd_type_i(cmd_type),
    .stat_rd_i(stat_rd), .stat_o(stat), .rate_cfg_i(rate_cfg),
    .indirect_i(indirect), .rep_lane_i(rep_lane), .dev_req_o(dev_req),
    .dev_lane_o(dev_lane), .dev_ack_i(dev_ack), .dev_err_i(dev_err),
    .dev_data_i(dev_data), .dev_flags_i(dev_flags),
    .mon_data_o(mon_data), .warn_o(warn)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [1:0] t);
    cmd_wr = 1'b1; cmd_type = t;
    tick(1);
    cmd_wr = 1'b0;
  endtask

  task automatic read_stat(output logic [1:0] s);
    s = stat; stat_rd = 1'b1;
    tick(1);
    stat_rd = 1'b0;
  endtask

  task automatic respond(input int lat, input logic [31:0] d, input logic [5:0] f, input bit err);
    for (int n = 0; n < 600 && !dev_req; n++) tick(1);
    tick(lat);
    dev_data = d; dev_flags = f; dev_ack = !err; dev_err = err;
    tick(1);
    dev_ack = 1'b0; dev_err = 1'b0;
  endtask

  task automatic gap(output int n);
    n = 0;
    while (!dev_req && n < 1000) begin n++; tick(1); end
  endtask

  task automatic quiet(input int len, output int hits);
    hits = 0;
    for (int i = 0; i < len; i++) begin if (dev_req) hits++; tick(1); end
  endtask

  task automatic hw_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    hw_reset(); tick(4);
    eq("R1 status", stat, 2'b00);
    eq("R1 req", dev_req, 0);
    eq("R1 data", mon_data, 0);
    eq("R1 flags", warn, 0);
  endtask

  task automatic t_single();
    logic [1:0] s;
    write_cmd(2'b00);
    eq("R2 busy", stat, 2'b10);
    eq("R2 req", dev_req, 1);
    respond(3, 32'hA1B2C3D4, 6'b100101, 0);
    eq("R2 done", stat, 2'b01);
    eq("R2 data", mon_data, 32'hA1B2C3D4);
    eq("R13 flags map", warn, 6'b100101);
    tick(5);
    eq("R4 held", stat, 2'b01);
    read_stat(s);
    eq("R4 read value", s, 2'b01);
    eq("R4 idle after read", stat, 2'b00);
  endtask

  task automatic t_guard();
    logic [1:0] s; int h;
    write_cmd(2'b00);
    write_cmd(2'b11);
    respond(2, 32'h11223344, 6'h00, 0);
    eq("R3 busy write ignored", stat, 2'b01);
    write_cmd(2'b01);
    tick(3);
    eq("R3 hold write no req", dev_req, 0);
    eq("R3 hold write status", stat, 2'b01);
    read_stat(s);
    quiet(20, h);
    eq("R3 no polling started", h, 0);
    eq("R3 idle", stat, 2'b00);
  endtask

  task automatic t_err();
    logic [1:0] s;
    write_cmd(2'b00);
    respond(1, 32'hDEADBEEF, 6'h3f, 1);
    eq("R5 failed", stat, 2'b11);
    eq("R5 data kept", mon_data, 32'h11223344);
    eq("R5 flags kept", warn, 6'h00);
    read_stat(s);
    eq("R4 fail read", s, 2'b11);
    eq("R4 idle after fail", stat, 2'b00);
  endtask

  task automatic t_watchdog();
    logic [1:0] s; int n;
    write_cmd(2'b00);
    n = 0;
    while (dev_req && n < 100) begin n++; tick(1); end
    eq("R6 req length", n, WD);
    eq("R6 failed", stat, 2'b11);
    read_stat(s);
  endtask

  task automatic t_atomic();
    logic [1:0] s;
    write_cmd(2'b00);
    dev_data = 32'h55AA55AA; dev_flags = 6'h2a;
    tick(4);
    eq("R13 no ack data", mon_data, 32'h11223344);
    eq("R13 no ack flags", warn, 6'h00);
    respond(0, 32'hCAFEF00D, 6'h01, 0);
    eq("R13 ack data", mon_data, 32'hCAFEF00D);
    read_stat(s);
  endtask

  task automatic t_periodic(input logic [1:0] t, input logic [1:0] rate, input int exp_gap, input string tag);
    int n, h;
    rate_cfg = rate;
    write_cmd(t);
    respond(1, 32'h01020304 + t, 6'h11, 0);
    eq({"R7 busy ", tag}, stat, 2'b10);
    eq({"R7 data1 ", tag}, mon_data, 32'h01020304 + t);
    gap(n);
    eq({"R8 gap ", tag}, n, exp_gap);
    respond(2, 32'hF0E0D0C0 + rate, 6'h22, 0);
    eq({"R7 data2 ", tag}, mon_data, 32'hF0E0D0C0 + rate);
    eq({"R7 flags2 ", tag}, warn, 6'h22);
    write_cmd(2'b00);
    eq({"R9 stopped ", tag}, stat, 2'b00);
    quiet(2 * exp_gap, h);
    eq({"R9 no req ", tag}, h, 0);
    rate_cfg = 2'd0;
  endtask

  task automatic t_lane();
    logic [1:0] s;
    indirect = 1'b1; rep_lane = 2'd2;
    write_cmd(2'b00);
    eq("R10 indirect lane", dev_lane, 2);
    respond(0, 32'h0, 6'h0, 0); read_stat(s);
    indirect = 1'b0; rep_lane = 2'd3;
    write_cmd(2'b00);
    eq("R10 direct lane", dev_lane, 0);
    respond(0, 32'h0, 6'h0, 0); read_stat(s);
  endtask

  task automatic t_auto_hw();
    int n, h;
    auto_pin = 1'b1; mon_ctrl = 1'b0;
    hw_reset();
    quiet(20, h);
    eq("R11 no start ctrl low", h, 0);
    mon_ctrl = 1'b1;
    hw_reset();
    n = 0;
    while (!dev_req && n < 10) begin n++; tick(1); end
    eq("R11 auto req", dev_req, 1);
    eq("R11 auto busy", stat, 2'b10);
    respond(0, 32'h77, 6'h0, 0);
    gap(n);
    eq("R11 fastest gap", n, FAST);
    respond(0, 32'h78, 6'h0, 0);
    write_cmd(2'b00);
    eq("R11 stop", stat, 2'b00);
    auto_pin = 1'b0; mon_ctrl = 1'b0;
  endtask

  task automatic t_soft();
    int n, h;
    write_cmd(2'b11);
    respond(0, 32'h99, 6'h3, 0);
    soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
    eq("R12 idle", stat, 2'b00);
    eq("R12 data cleared", mon_data, 0);
    eq("R12 flags cleared", warn, 0);
    quiet(30, h);
    eq("R12 polling ended", h, 0);
    auto_pin = 1'b1; mon_ctrl = 1'b1;
    soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
    n = 0;
    while (!dev_req && n < 4) begin n++; tick(1); end
    eq("R12 auto after soft", dev_req, 1);
    respond(0, 32'h5, 6'h0, 0);
    gap(n);
    eq("R12 fastest gap", n, FAST);
    respond(0, 32'h6, 6'h0, 0);
    write_cmd(2'b00);
    auto_pin = 1'b0; mon_ctrl = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 0; auto_pin = 0; mon_ctrl = 0; cmd_wr = 0;
    cmd_type = 0; stat_rd = 0; rate_cfg = 0; indirect = 0; rep_lane = 0;
    dev_ack = 0; dev_err = 0; dev_data = 0; dev_flags = 0;
    tick(1);
    t_reset();
    t_single();
    t_guard();
    t_err();
    t_watchdog();
    t_atomic();
    t_periodic(2'b11, 2'd0, FAST, "fast r0");
    t_periodic(2'b10, 2'd1, MID << 1, "mid r1");
    t_periodic(2'b01, 2'd0, SLOW, "slow r0");
    t_periodic(2'b11, 2'd2, FAST << 2, "fast r2");
    t_lane();
    t_soft();
    t_auto_hw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule